// File: doc/BRIEF.md
# Maintenance Bit Persistence Filter

This block sits behind a superframe deframer and debounces the 8-bit maintenance word that arrives once per superframe. Each bit position has its own persistence filter. A new value reaches the verified register only after it has been received in enough consecutive superframes. A 2-bit control selects the rule for the word: two in a row, three in a row, unfiltered copy, or freeze. A separate trinal flag forces the four status bits at the top of the word (bits 7..4) to use a three-in-a-row check, whatever the 2-bit control says.

Bit 7 of the word is the activation bit. Its verified value is brought out as a flag. The flag gates customer data transparency together with a software enable. The software enable is sampled only at interface-frame boundaries, so a change to it never takes effect part-way through a frame.

Each bit filter is a run-length state machine with four states:
- RUN_EMPTY is the reset state, in which nothing has been counted.
- RUN_ONE, RUN_TWO and RUN_THREE mean the candidate value has been seen in one, two, or three-or-more consecutive superframes.

An accepted strobe moves the filter as follows:
- If the incoming bit differs from the candidate, the filter loads the bit as the new candidate and goes to RUN_ONE.
- If the bit matches the candidate, the filter advances one state, and stays in RUN_THREE once there.

The transparency gate has two states, GATE_SHUT and GATE_PASS. At each frame boundary it goes to GATE_PASS if the software enable is 1 and to GATE_SHUT if it is 0.

Top module: `maint_persist_filter`

## Requirements
- R1: After reset, verified_bits is 0x00, and verified_act and xparent_en are 0.
- R2: A superframe strobe counts only when sf_sync is 1. With sf_sync at 0, or with no strobe, verified_bits does not change.
- R3: With ctl_mode 2'b00, a bit's new value is copied into verified_bits when it has been received in two consecutive counted superframes. A value seen only once has no effect.
- R4: With ctl_mode 2'b01, every bit needs three consecutive equal counted superframes before it is copied.
- R5: With ctl_mode 2'b10, every counted strobe copies sf_word into verified_bits unfiltered.
- R6: With ctl_mode 2'b11, verified_bits is frozen.
- R7: With trinal_en at 1, bits 7..4 need three consecutive equal counted superframes, whatever ctl_mode is.
- R8: With trinal_en at 1, bits 3..0 still follow the rule chosen by ctl_mode.
- R9: verified_act equals verified_bits bit 7 and changes in the same cycle.
- R10: xparent_en is the OR of verified_act and the gated customer enable.
- R11: A change of cust_en reaches xparent_en only at the clock edge where ifr_strobe is 1, and not at a superframe strobe.
- R12: A counted superframe that differs from the candidate restarts that bit's run from one. An interrupted sequence (A, B, A) therefore never verifies A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sf_strobe | input | 1 | One-cycle pulse: a new maintenance word is on sf_word |
| sf_word | input | 8 | Received maintenance word; bit 7 is activation |
| sf_sync | input | 1 | Superframe sync achieved; strobes are ignored while 0 |
| ctl_mode | input | 2 | 00 two-in-a-row, 01 three-in-a-row, 10 unfiltered, 11 freeze |
| trinal_en | input | 1 | Forces bits 7..4 to the three-in-a-row check |
| cust_en | input | 1 | Software customer enable |
| ifr_strobe | input | 1 | Interface-frame boundary pulse |
| verified_bits | output | 8 | Verified maintenance bits |
| verified_act | output | 1 | Verified activation bit |
| xparent_en | output | 1 | Customer data transparency enable |

## Verification
Four properties are checked on every cycle:
- verified_bits stays still without a counted strobe.
- verified_bits stays frozen in the freeze mode.
- The unfiltered mode, and the low nibble under the trinal flag with that mode, copy the received word one cycle later.
- xparent_en moves only on a frame boundary or a word update.

How many superframes each rule needs, the restart after an interrupted run, and the OR with the software enable depend on history over several strobes. Only the bench's directed scenarios show these, by checking after each strobe.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

    typedef enum logic [1:0] {
        RUN_EMPTY = 2'd0,
        RUN_ONE   = 2'd1,
        RUN_TWO   = 2'd2,
        RUN_THREE = 2'd3
    } run_e;

    typedef enum logic [1:0] {
        CTL_DUAL   = 2'b00,
        CTL_TRINAL = 2'b01,
        CTL_OPEN   = 2'b10,
        CTL_FREEZE = 2'b11
    } ctl_e;

    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_PASS = 1'b1
    } gate_e;

    // Per-bit update rule
    typedef struct packed {
        logic need3;   // three-in-a-row instead of two
        logic pass;    // copy every counted strobe
        logic hold;    // never update
    } rule_t;

endpackage

// File: rtl/mpf_rule_map.sv
module mpf_rule_map
    import mpf_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int DESIG_LO = 4
) (
    input  logic [1:0]        ctl_mode,
    input  logic              trinal_en,
    output logic [WORD_W-1:0] need3,
    output logic [WORD_W-1:0] pass,
    output logic [WORD_W-1:0] hold
);

    ctl_e mode;
    assign mode = ctl_e'(ctl_mode);

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        localparam bit DESIGNATED = (b >= DESIG_LO);
        always_comb begin
            need3[b] = 1'b0;
            pass[b]  = 1'b0;
            hold[b]  = 1'b0;
            if (DESIGNATED && trinal_en) begin
                need3[b] = 1'b1;
            end else begin
                unique case (mode)
                    CTL_DUAL:   need3[b] = 1'b0;
                    CTL_TRINAL: need3[b] = 1'b1;
                    CTL_OPEN:   pass[b]  = 1'b1;
                    CTL_FREEZE: hold[b]  = 1'b1;
                    default:    hold[b]  = 1'b1;
                endcase
            end
        end
    end

endmodule

// File: rtl/mpf_bit_filter.sv
module mpf_bit_filter
    import mpf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic din,
    input  logic need3,
    input  logic pass,
    input  logic hold,
    output logic q
);

    run_e run_q, run_d;
    logic cand_q, cand_d;
    logic reached;

    // Next-state logic of the run-length machine
    always_comb begin
        run_d  = run_q;
        cand_d = cand_q;
        if (take) begin
            if (din != cand_q) begin
                cand_d = din;
                run_d  = RUN_ONE;
            end else begin
                unique case (run_q)
                    RUN_EMPTY: run_d = RUN_ONE;
                    RUN_ONE:   run_d = RUN_TWO;
                    RUN_TWO:   run_d = RUN_THREE;
                    RUN_THREE: run_d = RUN_THREE;
                    default:   run_d = RUN_EMPTY;
                endcase
            end
        end
    end

    assign reached = need3 ? (run_d == RUN_THREE)
                           : ((run_d == RUN_TWO) || (run_d == RUN_THREE));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= RUN_EMPTY;
            cand_q <= 1'b0;
        end else begin
            run_q  <= run_d;
            cand_q <= cand_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (take && !hold) begin
            if (pass)
                q <= din;
            else if (reached)
                q <= cand_d;
        end
    end

endmodule

// File: rtl/mpf_xparency_gate.sv
module mpf_xparency_gate
    import mpf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boundary,
    input  logic sw_en,
    input  logic act,
    output logic open
);

    gate_e gate_q, gate_d;

    always_comb begin
        gate_d = gate_q;
        if (boundary) begin
            unique case (gate_q)
                GATE_SHUT: gate_d = sw_en ? GATE_PASS : GATE_SHUT;
                GATE_PASS: gate_d = sw_en ? GATE_PASS : GATE_SHUT;
                default:   gate_d = GATE_SHUT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gate_q <= GATE_SHUT;
        else
            gate_q <= gate_d;
    end

    assign open = act | (gate_q == GATE_PASS);

endmodule

// File: rtl/maint_persist_filter.sv
module maint_persist_filter
    import mpf_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int ACT_BIT  = 7,
    parameter int DESIG_LO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sf_strobe,
    input  logic [WORD_W-1:0] sf_word,
    input  logic              sf_sync,
    input  logic [1:0]        ctl_mode,
    input  logic              trinal_en,
    input  logic              cust_en,
    input  logic              ifr_strobe,
    output logic [WORD_W-1:0] verified_bits,
    output logic              verified_act,
    output logic              xparent_en
);

    logic              take;
    logic [WORD_W-1:0] need3, pass, hold;

    assign take = sf_strobe & sf_sync;

    mpf_rule_map #(.WORD_W(WORD_W), .DESIG_LO(DESIG_LO)) u_rules (
        .ctl_mode  (ctl_mode),
        .trinal_en (trinal_en),
        .need3     (need3),
        .pass      (pass),
        .hold      (hold)
    );

    for (genvar b = 0; b < WORD_W; b++) begin : g_filt
        mpf_bit_filter u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .take  (take),
            .din   (sf_word[b]),
            .need3 (need3[b]),
            .pass  (pass[b]),
            .hold  (hold[b]),
            .q     (verified_bits[b])
        );
    end

    assign verified_act = verified_bits[ACT_BIT];

    mpf_xparency_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (ifr_strobe),
        .sw_en    (cust_en),
        .act      (verified_act),
        .open     (xparent_en)
    );

endmodule

// File: rtl/maint_persist_chk.sv
module maint_persist_chk #(
    parameter int WORD_W   = 8,
    parameter int DESIG_LO = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sf_strobe,
    input logic [WORD_W-1:0] sf_word,
    input logic              sf_sync,
    input logic [1:0]        ctl_mode,
    input logic              trinal_en,
    input logic              ifr_strobe,
    input logic [WORD_W-1:0] verified_bits,
    input logic              xparent_en
);

    assert_hold_no_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sf_strobe && sf_sync) |=> $stable(verified_bits));

    assert_open_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_strobe && sf_sync && ctl_mode == 2'b10 && !trinal_en)
        |=> verified_bits == $past(sf_word));

    assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_mode == 2'b11 && !trinal_en) |=> $stable(verified_bits));

    assert_low_follows_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_strobe && sf_sync && ctl_mode == 2'b10 && trinal_en)
        |=> verified_bits[DESIG_LO-1:0] == $past(sf_word[DESIG_LO-1:0]));

    assert_gate_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ifr_strobe && !(sf_strobe && sf_sync)) |=> $stable(xparent_en));

endmodule

bind maint_persist_filter maint_persist_chk #(.WORD_W(WORD_W), .DESIG_LO(DESIG_LO)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sf_strobe     (sf_strobe),
    .sf_word       (sf_word),
    .sf_sync       (sf_sync),
    .ctl_mode      (ctl_mode),
    .trinal_en     (trinal_en),
    .ifr_strobe    (ifr_strobe),
    .verified_bits (verified_bits),
    .xparent_en    (xparent_en)
);

// File: tb/sim_maint_persist_filter.sv
module sim_maint_persist_filter;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sf_strobe, sf_sync, trinal_en, cust_en, ifr_strobe;
    logic [7:0] sf_word;
    logic [1:0] ctl_mode;
    logic [7:0] verified_bits;
    logic       verified_act, xparent_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    maint_persist_filter u0 (
        .clk(clk), .rst_n(rst_n), .sf_strobe(sf_strobe), .sf_word(sf_word),
        .sf_sync(sf_sync), .ctl_mode(ctl_mode), .trinal_en(trinal_en),
        .cust_en(cust_en), .ifr_strobe(ifr_strobe),
        .verified_bits(verified_bits), .verified_act(verified_act),
        .xparent_en(xparent_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sf_strobe = 1'b0; sf_word = 8'h00; sf_sync = 1'b1;
        ctl_mode = 2'b00; trinal_en = 1'b0; cust_en = 1'b0; ifr_strobe = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Strobe one word; outputs are sampled at the following falling edge
    task automatic send(input logic [7:0] w);
        sf_word = w; sf_strobe = 1'b1;
        @(negedge clk);
        sf_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 bits", verified_bits, 8'h00);
        check("R1 act", {7'd0, verified_act}, 8'h00);
        check("R1 xparent", {7'd0, xparent_en}, 8'h00);
    endtask

    task automatic t_nosync();
        do_reset();
        ctl_mode = 2'b10; sf_sync = 1'b0;
        send(8'hFF); send(8'hFF); send(8'hFF);
        check("R2 no sync", verified_bits, 8'h00);
        sf_sync = 1'b1; sf_word = 8'hFF;
        repeat (3) @(negedge clk);
        check("R2 no strobe", verified_bits, 8'h00);
    endtask

    task automatic t_dual();
        do_reset();
        send(8'h0F);
        check("R3 one seen", verified_bits, 8'h00);
        send(8'h0F);
        check("R3 two seen", verified_bits, 8'h0F);
        send(8'h3C);
        check("R3 glitch", verified_bits, 8'h0F);
        send(8'h0F);
        check("R12 back", verified_bits, 8'h0F);
        send(8'h3C);
        check("R12 restart", verified_bits, 8'h0F);
        send(8'h3C);
        check("R3 change", verified_bits, 8'h3C);
    endtask

    task automatic t_trinal_mode();
        do_reset();
        ctl_mode = 2'b01;
        send(8'hA5); send(8'hA5);
        check("R4 two seen", verified_bits, 8'h00);
        send(8'hA5);
        check("R4 three seen", verified_bits, 8'hA5);
    endtask

    task automatic t_open();
        do_reset();
        ctl_mode = 2'b10;
        send(8'h5A);
        check("R5 copy a", verified_bits, 8'h5A);
        send(8'hC3);
        check("R5 copy b", verified_bits, 8'hC3);
    endtask

    task automatic t_freeze();
        do_reset();
        ctl_mode = 2'b10;
        send(8'h19);
        ctl_mode = 2'b11;
        send(8'h66); send(8'h66); send(8'h66);
        check("R6 frozen", verified_bits, 8'h19);
    endtask

    task automatic t_desig();
        do_reset();
        ctl_mode = 2'b10; trinal_en = 1'b1;
        send(8'hFF);
        check("R8 low copy", verified_bits, 8'h0F);
        send(8'hFF);
        check("R7 two seen", verified_bits, 8'h0F);
        check("R9 act low", {7'd0, verified_act}, 8'h00);
        send(8'hFF);
        check("R7 three seen", verified_bits, 8'hFF);
        check("R9 act high", {7'd0, verified_act}, 8'h01);
        do_reset();
        ctl_mode = 2'b00; trinal_en = 1'b1;
        send(8'h81); send(8'h81);
        check("R8 dual low", verified_bits, 8'h01);
        send(8'h81);
        check("R7 dual high", verified_bits, 8'h81);
    endtask

    task automatic t_act();
        do_reset();
        ctl_mode = 2'b10;
        send(8'h80);
        check("R9 act set", {7'd0, verified_act}, 8'h01);
        check("R10 act opens", {7'd0, xparent_en}, 8'h01);
        send(8'h00);
        check("R9 act clear", {7'd0, verified_act}, 8'h00);
        check("R10 shut", {7'd0, xparent_en}, 8'h00);
    endtask

    task automatic t_cust();
        do_reset();
        ctl_mode = 2'b10;
        cust_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 wait", {7'd0, xparent_en}, 8'h00);
        send(8'h00);
        check("R11 not superframe", {7'd0, xparent_en}, 8'h00);
        ifr_strobe = 1'b1;
        @(negedge clk);
        ifr_strobe = 1'b0;
        check("R11 boundary", {7'd0, xparent_en}, 8'h01);
        cust_en = 1'b0;
        @(negedge clk);
        check("R11 hold", {7'd0, xparent_en}, 8'h01);
        send(8'h80);
        ifr_strobe = 1'b1;
        @(negedge clk);
        ifr_strobe = 1'b0;
        check("R10 act or", {7'd0, xparent_en}, 8'h01);
        send(8'h00);
        check("R10 both off", {7'd0, xparent_en}, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0; sf_strobe = 1'b0; sf_word = 8'h00; sf_sync = 1'b0;
        ctl_mode = 2'b00; trinal_en = 1'b0; cust_en = 1'b0; ifr_strobe = 1'b0;
        t_reset();
        t_nosync();
        t_dual();
        t_trinal_mode();
        t_open();
        t_freeze();
        t_desig();
        t_act();
        t_cust();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule